// File: doc/BRIEF.md
# Eight-Source Priority Interrupt Controller

This block collects eight interrupt requests and reduces them to one request line and a 3-bit vector for a host processor. Sources 0 to 3 come from user-defined request inputs and sources 4 to 7 come from counter terminal-count signals. Each source has its own enable (through a mask) and its own sensitivity choice: it can capture rising edges into a pending latch, or it can follow its input as a level.

The highest-priority unmasked pending source is shown on the vector output whenever the request output is high. The host services an interrupt by pulsing a read strobe. The source shown on the vector in that cycle then has its captured edge cleared. A level source stays pending for as long as its input is high, so it must be quietened at its origin.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After the active-low asynchronous reset no edge is captured, so with all inputs low `irq_o` is 0 and `vec_o` is 0.
- R2: Source k for k in 0..3 is `usr_irq_i[k]`, and source k for k in 4..7 is `tc_i[k-4]`. `vec_o` carries the selected source index in plain binary.
- R3: When `edge_i[k]`=1, a rising edge on source k latches a pending bit. The edge counts when the input is sampled low at one clock and high at the next. The bit is visible after that second clock and stays set after the input falls, until it is cleared by a read.
- R4: When `edge_i[k]`=0, source k is pending in the same cycle that its input is high and not pending when it is low. A read never removes it.
- R5: `mask_i[k]`=1 keeps source k out of `irq_o` and out of vector selection. A masked edge source still latches its pending bit, and the bit takes effect when the mask is lifted.
- R6: Among unmasked pending sources, the lowest index wins. `vec_o` is 0 when nothing is selected.
- R7: `irq_o` is 1 exactly when at least one unmasked source is pending.
- R8: A clock edge with `rd_i`=1 and `irq_o`=1 clears the edge-pending bit of the source that `vec_o` shows in that cycle. Other pending bits are left unchanged.
- R9: A rising edge that is sampled at the same clock as a read does not change which source that read clears. If it is on the source being cleared, the new edge wins and the source stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| usr_irq_i | input | 4 | User-defined requests, sources 0..3 |
| tc_i | input | 4 | Counter terminal counts, sources 4..7 |
| mask_i | input | 8 | 1 = source blocked |
| edge_i | input | 8 | 1 = edge-sensitive, 0 = level-sensitive |
| rd_i | input | 1 | Vector read strobe, clears serviced source |
| vec_o | output | 3 | Index of selected source |
| irq_o | output | 1 | Any unmasked source pending |

## Verification
Two things can happen in the same clock cycle: a vector read that clears a pending bit, and a new rising edge that sets one. The bench provokes this in two ways. First, it reads source 3 while source 0 rises; the read must report 3, and the next cycle must show 0 with source 3 gone. Second, it reads source 4 while that same input rises again; source 4 must still be pending afterwards and must need a second read to clear it.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned IRQ_N_USR = 4;
  localparam int unsigned IRQ_N_TC  = 4;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] rise_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= src_i[k];
    end
    assign rise_o[k] = src_i[k] & ~prev_q;
  end
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int unsigned N  = 8,
  parameter int unsigned VW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  rise_i,
  input  logic [N-1:0]  edge_i,
  input  logic          clr_i,
  input  logic [VW-1:0] clr_idx_i,
  output logic [N-1:0]  pend_o
);
  for (genvar k = 0; k < N; k++) begin : g_pend
    logic set_w, clr_w;
    assign set_w = rise_i[k] & edge_i[k];
    assign clr_w = clr_i && (clr_idx_i == VW'(k));
    // new edge beats a clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    pend_o[k] <= 1'b0;
      else if (set_w) pend_o[k] <= 1'b1;
      else if (clr_w) pend_o[k] <= 1'b0;
    end

    // R3
    pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_i[k] && edge_i[k] |=> pend_o[k]);
    // R8
    pend_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i && clr_idx_i != VW'(k) && pend_o[k] |=> pend_o[k]);
  end

  // R8
  pend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !rise_i[clr_idx_i] |=> !pend_o[$past(clr_idx_i)]);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N  = 8,
  parameter int unsigned VW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [VW-1:0] vec_o,
  output logic          any_o
);
  always_comb begin
    vec_o = '0;
    any_o = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        vec_o = VW'(k);
        any_o = 1'b1;
      end
    end
  end

  always_comb begin
    if (any_o) begin
      // R6
      enc_pick_chk: assert (req_i[vec_o]);
      // R6
      enc_top_chk: assert ((req_i & ((N'(1) << vec_o) - N'(1))) == '0);
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N_USR = IRQ_N_USR,
  parameter int unsigned N_TC  = IRQ_N_TC,
  localparam int unsigned N_SRC = N_USR + N_TC,
  localparam int unsigned VW    = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_USR-1:0] usr_irq_i,
  input  logic [N_TC-1:0]  tc_i,
  input  logic [N_SRC-1:0] mask_i,
  input  logic [N_SRC-1:0] edge_i,
  input  logic             rd_i,
  output logic [VW-1:0]    vec_o,
  output logic             irq_o
);
  logic [N_SRC-1:0] src_w, rise_w, pend_q, eff_w, req_w;

  assign src_w = {tc_i, usr_irq_i};

  irq_edge_det #(.N(N_SRC)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_w),
    .rise_o (rise_w)
  );

  // vector sampled at the strobe selects the clear target
  irq_pend #(.N(N_SRC), .VW(VW)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise_w),
    .edge_i    (edge_i),
    .clr_i     (rd_i & irq_o),
    .clr_idx_i (vec_o),
    .pend_o    (pend_q)
  );

  assign eff_w = (pend_q & edge_i) | (src_w & ~edge_i);
  assign req_w = eff_w & ~mask_i;

  irq_prio_enc #(.N(N_SRC), .VW(VW)) u_enc (
    .req_i (req_w),
    .vec_o (vec_o),
    .any_o (irq_o)
  );

  for (genvar k = 0; k < N_SRC; k++) begin : g_lvl
    // R4
    lvl_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !edge_i[k] && src_w[k] && !mask_i[k] |-> irq_o);
    // R5
    mask_hide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mask_i[k] && irq_o |-> vec_o != VW'(k));
  end

  // R6
  idle_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> vec_o == '0);
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] usr = '0, tc = '0;
  logic [7:0] mask = '0, edg = 8'hFF;
  logic       rd = 1'b0;
  logic [2:0] vec;
  logic       irq;

  int n_chk = 0, n_bad = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  always #5 clk = ~clk;

  irq_prio_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .usr_irq_i(usr), .tc_i(tc),
    .mask_i(mask), .edge_i(edg), .rd_i(rd), .vec_o(vec), .irq_o(irq)
  );

  // monitor: compares at negedge + 3
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (exp_q.size() > 0) begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if ({irq, vec} !== e) begin
          n_bad++;
          $display("FAIL %s: irq/vec got %0b/%0d exp %0b/%0d", t, irq, vec, e[3], e[2:0]);
        end
      end
    end
  end

  task automatic t(input logic [3:0] u, input logic [3:0] c, input logic [7:0] m,
                   input logic [7:0] e, input logic r, input logic [2:0] xv,
                   input logic xi, input string tag);
    @(negedge clk);
    usr = u; tc = c; mask = m; edg = e; rd = r;
    #2;
    exp_q.push_back({xi, xv});
    tag_q.push_back(tag);
  endtask

  initial begin
    #100_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t(0, 0, 8'h00, 8'hFF, 0, 0, 0, "R1 reset idle");
    // edge capture on source 2
    t(4'h4, 0, 8'h00, 8'hFF, 0, 0, 0, "R3 edge not yet latched");
    t(4'h4, 0, 8'h00, 8'hFF, 0, 2, 1, "R3 R2 latched src2");
    t(0, 0, 8'h00, 8'hFF, 0, 2, 1, "R3 held after fall");
    t(0, 0, 8'h00, 8'hFF, 1, 2, 1, "R8 read sample src2");
    t(0, 0, 8'h00, 8'hFF, 0, 0, 0, "R8 src2 cleared");
    // priority src1 vs src5
    t(4'h2, 4'h2, 8'h00, 8'hFF, 0, 0, 0, "R6 pre");
    t(0, 0, 8'h00, 8'hFF, 0, 1, 1, "R6 src1 wins");
    t(0, 0, 8'h00, 8'hFF, 1, 1, 1, "R8 read src1");
    t(0, 0, 8'h00, 8'hFF, 0, 5, 1, "R8 R2 src5 remains");
    t(0, 0, 8'h00, 8'hFF, 1, 5, 1, "R8 read src5");
    t(0, 0, 8'h00, 8'hFF, 0, 0, 0, "R8 all clear");
    // mask src1, src6 pending
    t(4'h2, 4'h4, 8'h02, 8'hFF, 0, 0, 0, "R5 pre");
    t(0, 0, 8'h02, 8'hFF, 0, 6, 1, "R5 masked src1 skipped");
    t(0, 0, 8'h00, 8'hFF, 0, 1, 1, "R5 pending kept under mask");
    t(0, 0, 8'h00, 8'hFF, 1, 1, 1, "R5 read src1");
    t(0, 0, 8'h00, 8'hFF, 0, 6, 1, "R5 src6 next");
    t(0, 0, 8'h00, 8'hFF, 1, 6, 1, "R5 read src6");
    t(0, 0, 8'h00, 8'hFF, 0, 0, 0, "R5 clear");
    t(0, 4'h2, 8'h20, 8'hFF, 0, 0, 0, "R7 masked only pre");
    t(0, 0, 8'h20, 8'hFF, 0, 0, 0, "R7 masked pending no irq");
    t(0, 0, 8'h00, 8'hFF, 0, 5, 1, "R7 unmask src5");
    t(0, 0, 8'h00, 8'hFF, 1, 5, 1, "R8 read src5 again");
    // level source 0
    t(4'h1, 0, 8'h00, 8'hFE, 0, 0, 1, "R4 same cycle");
    t(4'h1, 0, 8'h00, 8'hFE, 1, 0, 1, "R4 read level");
    t(4'h1, 0, 8'h00, 8'hFE, 0, 0, 1, "R4 not cleared by read");
    t(0, 0, 8'h00, 8'hFE, 0, 0, 0, "R4 drop");
    // read collides with higher-priority edge
    t(4'h8, 0, 8'h00, 8'hFF, 0, 0, 0, "R9 pre");
    t(0, 0, 8'h00, 8'hFF, 0, 3, 1, "R9 src3 pending");
    t(4'h1, 0, 8'h00, 8'hFF, 1, 3, 1, "R9 read samples src3");
    t(0, 0, 8'h00, 8'hFF, 0, 0, 1, "R9 src0 after, src3 gone");
    t(0, 0, 8'h00, 8'hFF, 1, 0, 1, "R9 read src0");
    t(0, 0, 8'h00, 8'hFF, 0, 0, 0, "R9 clear");
    // read collides with new edge on same source
    t(0, 4'h1, 8'h00, 8'hFF, 0, 0, 0, "R9 tc0 rise");
    t(0, 0, 8'h00, 8'hFF, 0, 4, 1, "R9 R2 src4 pending");
    t(0, 4'h1, 8'h00, 8'hFF, 1, 4, 1, "R9 read with new edge");
    t(0, 0, 8'h00, 8'hFF, 0, 4, 1, "R9 new edge kept");
    t(0, 0, 8'h00, 8'hFF, 1, 4, 1, "R9 second read");
    t(0, 0, 8'h00, 8'hFF, 0, 0, 0, "R9 done");
    // level src7 vs mask
    t(0, 4'h8, 8'hFF, 8'h7F, 0, 0, 0, "R7 all masked");
    t(0, 4'h8, 8'h00, 8'h7F, 0, 7, 1, "R7 R2 level src7");
    t(0, 0, 8'h00, 8'hFF, 0, 0, 0, "R7 idle");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule